// File: doc/BRIEF.md
# Forward-Channel Tagged FIFO Transmitter for a Parallel Printer Port

This block moves bytes from a host toward a peripheral over the forward direction of an extended-capability parallel port. Software or a DMA engine pushes bytes into a single shared queue through one of two write ports. A byte written through the data port is tagged as data. A byte written through the command port is tagged as a command. Command bytes below 0x80 are run counts, and those at or above 0x80 are channel addresses. The peripheral decodes the meaning; the block passes the byte through unchanged. For a compressed run, software writes the repeat count through the command port and then the byte to repeat through the data port.

A transmit engine takes the entry at the head of the queue and places it on the parallel data lines. It then runs one of two strobe protocols, selected by a 3-bit mode register. The peripheral's Busy line passes through a stability filter before the engine acts on it, so that ringing on the cable cannot advance the handshake. A DMA request output is throttled by queue occupancy with a programmable refill threshold. Any write to the mode register empties the queue and returns the engine to idle.

Top module: `pp_fwd_xmit`

## Requirements
- R1: After reset, n_strobe and host_ack are 1, fifo_empty is 1, fifo_full is 0, dma_req is 0 and mode_out is 3'b000.
- R2: While mode_out is neither 3'b010 (strobed FIFO mode) nor 3'b011 (handshaked FIFO mode), writes through the data, command and DMA ports are ignored and the queue stays empty.
- R3: In mode 3'b011, entries leave in the order they were written, with the byte unchanged on pd. host_ack is 1 for an entry from the data or DMA port and 0 for an entry from the command port.
- R4: In mode 3'b011, each entry is sent in this order: pd and host_ack are set while n_strobe is high; n_strobe goes low and stays low until the filtered Busy is high; n_strobe returns high; the entry is removed only after the filtered Busy is low. pd is held constant from strobe assertion until Busy falls.
- R5: A change on busy_in takes effect only after the new level has held for BUSY_STABLE (default 7) consecutive clocks. A shorter pulse has no effect on the handshake.
- R6: The queue holds DEPTH (default 16) entries. fifo_full is 1 when all DEPTH entries are occupied. A write while full is discarded, and the discarded byte is never sent.
- R7: In mode 3'b010, the engine waits until the filtered Busy is low, then drives n_strobe low for exactly STB_CYCLES (default 4) clocks and removes the entry. host_ack stays 1, and writes through the command port are ignored.
- R8: A write to the mode register empties the queue. By the following clock, fifo_empty is 1 and n_strobe is 1.
- R9: dma_req is 0 unless dma_en is 1 and the block is in mode 3'b010 or 3'b011. It falls when the queue becomes full, and it rises again once occupancy is at most DEPTH minus dma_thresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load mode_in into the mode register and flush the queue |
| mode_in | input | 3 | New mode value |
| dat_wr | input | 1 | Host write through the data port |
| cmd_wr | input | 1 | Host write through the command port |
| dma_wr | input | 1 | DMA write, tagged as data |
| wr_byte | input | 8 | Byte for any of the three write strobes |
| dma_en | input | 1 | Allow DMA requests |
| dma_thresh | input | CNT_W (5) | Free slots needed before dma_req returns |
| busy_in | input | 1 | Raw Busy from the peripheral |
| pd | output | 8 | Parallel data lines |
| n_strobe | output | 1 | Active-low strobe |
| host_ack | output | 1 | Low for command entries in handshaked mode |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| dma_req | output | 1 | DMA request |
| mode_out | output | 3 | Current mode register |

## Verification
The case hardest to reach from the ports is a queue that is completely full. It needs 16 entries resident at once, which can only happen if the engine is stalled. The bench stalls it by leaving Busy low during a handshaked transfer, so the head entry stays in flight. It then fills the queue, pushes one extra byte and finally serves every entry. The same stall, released one entry at a time, walks occupancy across the DMA threshold so that the exact level at which dma_req returns can be observed. Busy glitches are injected while the strobe is low, because that is the only state in which a false edge could advance the handshake.

// File: rtl/pp_fwd_pkg.sv
package pp_fwd_pkg;

   localparam int BYTE_W = 8;

   localparam logic [2:0] MODE_COMPAT   = 3'b000;
   localparam logic [2:0] MODE_FIFO_STB = 3'b010;
   localparam logic [2:0] MODE_FIFO_HS  = 3'b011;

   typedef struct packed {
      logic              is_cmd;
      logic [BYTE_W-1:0] val;
   } entry_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_RELEASE
   } xmit_state_t;

endpackage

// File: rtl/pp_tag_fifo.sv
module pp_tag_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 9,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] level
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pp_tag_fifo: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             push_ok;
   logic             pop_ok;

   assign full    = (level == CNT_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);

   // R4
   pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/pp_busy_filter.sv
module pp_busy_filter #(
   parameter int STABLE = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_raw,
   output logic busy_clean
);

   generate
      if (STABLE < 0) begin : g_bad_stable
         $error("pp_busy_filter: STABLE must not be negative");
      end

      if (STABLE == 0) begin : g_bypass
         assign busy_clean = busy_raw;
      end else begin : g_count
         localparam int CW = $clog2(STABLE + 1);
         logic [CW-1:0] run;
         logic          held;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held <= 1'b0;
               run  <= '0;
            end else if (busy_raw == held) begin
               run <= '0;
            end else if (run == CW'(STABLE - 1)) begin
               held <= busy_raw;
               run  <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end

         assign busy_clean = held;

         // R5
         busy_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_clean != $past(busy_clean)) |-> ($past(busy_raw) == busy_clean));
      end
   endgenerate

endmodule

// File: rtl/pp_fwd_engine.sv
module pp_fwd_engine
   import pp_fwd_pkg::*;
#(
   parameter int STB_CYCLES = 4,
   localparam int SW = $clog2(STB_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic [2:0]        mode,
   input  entry_t            head,
   input  logic              head_valid,
   input  logic              busy_f,
   output logic              pop,
   output logic [BYTE_W-1:0] pd,
   output logic              host_ack,
   output logic              n_strobe
);

   generate
      if (STB_CYCLES < 1) begin : g_bad_stb
         $error("pp_fwd_engine: STB_CYCLES must be at least 1");
      end
   endgenerate

   xmit_state_t state;
   logic [SW-1:0] hold_cnt;
   logic          hs_mode;
   logic          stb_mode;
   logic          stb_done;

   assign hs_mode  = (mode == MODE_FIFO_HS);
   assign stb_mode = (mode == MODE_FIFO_STB);
   assign stb_done = (hold_cnt == SW'(STB_CYCLES - 1));
   assign n_strobe = (state != ST_STROBE);

   always_comb begin
      pop = 1'b0;
      if (!abort) begin
         if (state == ST_STROBE && !hs_mode && stb_done) pop = 1'b1;
         if (state == ST_RELEASE && !busy_f)             pop = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hold_cnt <= '0;
         pd       <= '0;
         host_ack <= 1'b1;
      end else if (abort) begin
         state    <= ST_IDLE;
         hold_cnt <= '0;
         host_ack <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               hold_cnt <= '0;
               if (head_valid && (hs_mode || stb_mode)) begin
                  pd       <= head.val;
                  host_ack <= hs_mode ? !head.is_cmd : 1'b1;
                  state    <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (hs_mode || !busy_f) state <= ST_STROBE;
            end
            ST_STROBE: begin
               if (hs_mode) begin
                  if (busy_f) state <= ST_RELEASE;
               end else if (stb_done) begin
                  state <= ST_IDLE;
               end else begin
                  hold_cnt <= hold_cnt + 1'b1;
               end
            end
            ST_RELEASE: begin
               if (!busy_f) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R4
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!n_strobe && $past(!n_strobe)) |-> $stable(pd));

   // R4
   hs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_mode && $rose(n_strobe) && !$past(abort)) |-> $past(busy_f));

endmodule

// File: rtl/pp_fwd_xmit.sv
module pp_fwd_xmit
   import pp_fwd_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int BUSY_STABLE = 7,
   parameter int STB_CYCLES  = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_in,
   input  logic              dat_wr,
   input  logic              cmd_wr,
   input  logic              dma_wr,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              dma_en,
   input  logic [CNT_W-1:0]  dma_thresh,
   input  logic              busy_in,
   output logic [BYTE_W-1:0] pd,
   output logic              n_strobe,
   output logic              host_ack,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              dma_req,
   output logic [2:0]        mode_out
);

   logic [2:0]       mode_q;
   logic             fifo_mode;
   logic             cmd_ok;
   logic             push;
   entry_t           wr_entry;
   entry_t           head;
   logic             pop;
   logic             busy_f;
   logic [CNT_W-1:0] level;
   logic             drq_q;

   assign mode_out  = mode_q;
   assign fifo_mode = (mode_q == MODE_FIFO_HS) || (mode_q == MODE_FIFO_STB);
   assign cmd_ok    = cmd_wr && (mode_q == MODE_FIFO_HS);
   assign push      = fifo_mode && !mode_wr && (cmd_ok || dat_wr || dma_wr);
   assign wr_entry  = '{is_cmd: cmd_ok, val: wr_byte};
   assign dma_req   = drq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= MODE_COMPAT;
      else if (mode_wr) mode_q <= mode_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !dma_en || !fifo_mode || mode_wr)
         drq_q <= 1'b0;
      else if (fifo_full)
         drq_q <= 1'b0;
      else if ({1'b0, level} + {1'b0, dma_thresh} <= (CNT_W + 1)'(DEPTH))
         drq_q <= 1'b1;
   end

   pp_tag_fifo #(
      .DEPTH (DEPTH),
      .W     ($bits(entry_t))
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (mode_wr),
      .push  (push),
      .din   (wr_entry),
      .pop   (pop),
      .dout  (head),
      .full  (fifo_full),
      .empty (fifo_empty),
      .level (level)
   );

   pp_busy_filter #(
      .STABLE (BUSY_STABLE)
   ) u_busy (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_raw   (busy_in),
      .busy_clean (busy_f)
   );

   pp_fwd_engine #(
      .STB_CYCLES (STB_CYCLES)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort      (mode_wr),
      .mode       (mode_q),
      .head       (head),
      .head_valid (!fifo_empty),
      .busy_f     (busy_f),
      .pop        (pop),
      .pd         (pd),
      .host_ack   (host_ack),
      .n_strobe   (n_strobe)
   );

   // R9
   drq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |=> !dma_req);

   // R8
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> (fifo_empty && n_strobe));

endmodule

// File: tb/pp_fwd_xmit_test.sv
module pp_fwd_xmit_test;

   localparam int DEPTH  = 16;
   localparam int STABLE = 7;
   localparam int STB    = 4;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n;
   logic             mode_wr = 1'b0;
   logic [2:0]       mode_in = 3'b000;
   logic             dat_wr = 1'b0;
   logic             cmd_wr = 1'b0;
   logic             dma_wr = 1'b0;
   logic [7:0]       wr_byte = 8'h00;
   logic             dma_en = 1'b0;
   logic [CNT_W-1:0] dma_thresh = '0;
   logic             busy_in = 1'b0;
   logic [7:0]       pd;
   logic             n_strobe;
   logic             host_ack;
   logic             fifo_full;
   logic             fifo_empty;
   logic             dma_req;
   logic [2:0]       mode_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pp_fwd_xmit #(
      .DEPTH (DEPTH), .BUSY_STABLE (STABLE), .STB_CYCLES (STB)
   ) uut (
      .clk (clk), .rst_n (rst_n), .mode_wr (mode_wr), .mode_in (mode_in),
      .dat_wr (dat_wr), .cmd_wr (cmd_wr), .dma_wr (dma_wr), .wr_byte (wr_byte),
      .dma_en (dma_en), .dma_thresh (dma_thresh), .busy_in (busy_in),
      .pd (pd), .n_strobe (n_strobe), .host_ack (host_ack),
      .fifo_full (fifo_full), .fifo_empty (fifo_empty), .dma_req (dma_req),
      .mode_out (mode_out)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input int kind, input logic [7:0] b);
      @(negedge clk);
      wr_byte = b;
      dat_wr  = (kind == 0);
      cmd_wr  = (kind == 1);
      dma_wr  = (kind == 2);
      @(negedge clk);
      dat_wr = 1'b0; cmd_wr = 1'b0; dma_wr = 1'b0;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode_in = m; mode_wr = 1'b1;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   task automatic serve(output logic [7:0] b, output logic a);
      while (n_strobe !== 1'b0) @(negedge clk);
      b = pd; a = host_ack;
      idle(2);
      busy_in = 1'b1;
      idle(STABLE - 2);
      chk(n_strobe === 1'b0, "R4 strobe held until busy settles", 32'(n_strobe), 0);
      while (n_strobe !== 1'b1) @(negedge clk);
      chk(pd === b, "R4 data held while busy", 32'(pd), 32'(b));
      busy_in = 1'b0;
      idle(STABLE + 3);
   endtask

   task automatic t_reset();
      chk(n_strobe === 1'b1 && host_ack === 1'b1, "R1 strobe/ack idle",
          {30'd0, n_strobe, host_ack}, 3);
      chk(fifo_empty === 1'b1 && fifo_full === 1'b0, "R1 flags",
          {30'd0, fifo_empty, fifo_full}, 2);
      chk(dma_req === 1'b0 && mode_out === 3'b000, "R1 drq/mode",
          {28'd0, dma_req, mode_out}, 0);
   endtask

   task automatic t_ignore();
      put(0, 8'h11); put(1, 8'h22); put(2, 8'h33);
      idle(6);
      chk(fifo_empty === 1'b1, "R2 writes ignored in mode 000", 32'(fifo_empty), 1);
      chk(n_strobe === 1'b1, "R2 no strobe in mode 000", 32'(n_strobe), 1);
   endtask

   task automatic t_hs_order();
      logic [7:0] b; logic a;
      logic [7:0] eb [4] = '{8'h05, 8'h41, 8'h82, 8'h7E};
      logic       ea [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
      set_mode(3'b011);
      put(1, 8'h05); put(0, 8'h41); put(1, 8'h82); put(0, 8'h7E);
      for (int i = 0; i < 4; i++) begin
         serve(b, a);
         chk(b === eb[i], "R3 byte order", 32'(b), 32'(eb[i]));
         chk(a === ea[i], "R3 host_ack tag", 32'(a), 32'(ea[i]));
      end
      chk(fifo_empty === 1'b1 && n_strobe === 1'b1, "R4 idle after last entry",
          {30'd0, fifo_empty, n_strobe}, 3);
   endtask

   task automatic t_glitch();
      logic [7:0] b; logic a;
      put(0, 8'h33);
      while (n_strobe !== 1'b0) @(negedge clk);
      busy_in = 1'b1; idle(3); busy_in = 1'b0;
      idle(12);
      chk(n_strobe === 1'b0, "R5 short busy pulse ignored", 32'(n_strobe), 0);
      serve(b, a);
      chk(b === 8'h33, "R5 byte after glitch", 32'(b), 32'h33);
   endtask

   task automatic t_full();
      logic [7:0] b; logic a;
      for (int i = 0; i < DEPTH; i++) put(0, 8'(8'h10 + i));
      chk(fifo_full === 1'b1, "R6 full after 16 writes", 32'(fifo_full), 1);
      put(0, 8'hEE);
      for (int i = 0; i < DEPTH; i++) begin
         serve(b, a);
         chk(b === 8'(8'h10 + i), "R6 stored byte", 32'(b), 32'(8'h10 + i));
      end
      idle(10);
      chk(fifo_empty === 1'b1 && n_strobe === 1'b1, "R6 write when full discarded",
          {30'd0, fifo_empty, n_strobe}, 3);
   endtask

   task automatic t_flush();
      put(0, 8'hA1); put(0, 8'hA2); put(0, 8'hA3);
      while (n_strobe !== 1'b0) @(negedge clk);
      set_mode(3'b011);
      chk(fifo_empty === 1'b1, "R8 mode write flushes", 32'(fifo_empty), 1);
      chk(n_strobe === 1'b1, "R8 strobe released", 32'(n_strobe), 1);
      idle(20);
      chk(n_strobe === 1'b1, "R8 nothing left to send", 32'(n_strobe), 1);
   endtask

   task automatic t_strobe_mode();
      int low;
      set_mode(3'b010);
      put(1, 8'h99);
      idle(6);
      chk(fifo_empty === 1'b1, "R7 command write ignored", 32'(fifo_empty), 1);
      put(0, 8'h5A);
      while (n_strobe !== 1'b0) @(negedge clk);
      chk(pd === 8'h5A && host_ack === 1'b1, "R7 byte and ack",
          {23'd0, host_ack, pd}, 32'h15A);
      low = 0;
      while (n_strobe === 1'b0) begin low++; @(negedge clk); end
      chk(low == STB, "R7 strobe width", 32'(low), 32'(STB));
      busy_in = 1'b1; idle(STABLE + 3);
      put(0, 8'h66);
      idle(20);
      chk(n_strobe === 1'b1, "R7 waits for busy low", 32'(n_strobe), 1);
      busy_in = 1'b0;
      idle(STABLE + 4);
      while (n_strobe !== 1'b0) @(negedge clk);
      chk(pd === 8'h66, "R7 byte after busy low", 32'(pd), 32'h66);
      idle(10);
      chk(fifo_empty === 1'b1, "R7 entry removed", 32'(fifo_empty), 1);
   endtask

   task automatic t_dma();
      logic [7:0] b; logic a;
      set_mode(3'b011);
      dma_thresh = CNT_W'(4);
      dma_en = 1'b1;
      idle(3);
      chk(dma_req === 1'b1, "R9 request with space", 32'(dma_req), 1);
      for (int i = 0; i < DEPTH; i++) put(2, 8'(8'hC0 + i));
      idle(2);
      chk(dma_req === 1'b0 && fifo_full === 1'b1, "R9 drop at full",
          {30'd0, dma_req, fifo_full}, 1);
      for (int i = 0; i < 3; i++) serve(b, a);
      chk(dma_req === 1'b0, "R9 still low at 13 entries", 32'(dma_req), 0);
      serve(b, a);
      chk(dma_req === 1'b1, "R9 back at 12 entries", 32'(dma_req), 1);
      chk(b === 8'hC3 && a === 1'b1, "R3 dma entry tagged data",
          {23'd0, a, b}, 32'h1C3);
      for (int i = 0; i < DEPTH - 4; i++) serve(b, a);
      dma_en = 1'b0;
      idle(3);
      chk(dma_req === 1'b0, "R9 disabled", 32'(dma_req), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_ignore();
      t_hs_order();
      t_glitch();
      t_full();
      t_flush();
      t_strobe_mode();
      t_dma();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule